// File: doc/BRIEF.md
# Reset Sequencer with Serial Boot-Mode Loader

This block brings a core out of power-on, cold and warm resets and, on the way, collects a serial configuration stream from the board. Once the power-good input goes high, it drives a slow mode clock derived from the system clock. It takes one bit of the serial mode input on each rising edge of that clock and builds a parallel mode word, least significant bit first. When the last bit has arrived, the word is flagged as valid.

The internal core reset is held until the mode word is complete and both external reset inputs are low. A warm reset or a cold reset with power still good keeps the mode word, so the core restarts with the same configuration and no second serial load. When power-good drops, the word is discarded and a fresh load begins on the next rise. The divide ratio and the stream length are parameters; both default to 256.

Top module: `boot_reset_ctrl`

## Requirements
- R1: Number the system clock edges from 1, starting with the first edge at which power_good is sampled high. After edge n, mode_clk is high exactly when (n mod DIV) >= DIV/2, so it is a square wave with a period of DIV cycles. DIV must be a power of two.
- R2: mode_in is sampled at every edge at which mode_clk goes from low to high, that is at edge n = DIV/2 + k*DIV for k = 0 .. MODE_W-1. The bit taken for k lands in mode_bits[k], so the first bit ends up in the least significant position.
- R3: mode_valid goes high right after the edge that takes the last bit (n = DIV/2 + (MODE_W-1)*DIV). mode_bits reads all zero whenever mode_valid is low.
- R4: While power_good stays high after loading, mode_valid and mode_bits hold their values and further mode_in activity is ignored.
- R5: Asserting warm_rst_in on its own, or cold_rst_in with power_good high, leaves mode_valid and mode_bits unchanged and does not restart the serial load.
- R6: core_rst is high, with no clock edge needed, whenever warm_rst_in, cold_rst_in or a low power_good is present. It is also high while mode_valid is low.
- R7: core_rst goes low right after the first edge at which mode_valid is already high and both reset inputs are sampled low. Without any reset inputs, this is one edge after mode_valid rises.
- R8: power_good low at a clock edge clears mode_valid, mode_bits and the mode clock (mode_clk low). Its next rise restarts the load at bit 0 with a fresh divider phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| power_good | input | 1 | Core supply good; high starts the load, low clears all state |
| cold_rst_in | input | 1 | Cold reset request, released synchronously |
| warm_rst_in | input | 1 | Reset request present in every reset sequence; alone it is a warm reset |
| mode_in | input | 1 | Serial boot-mode data |
| mode_clk | output | 1 | Mode clock, system clock divided by DIV |
| mode_bits | output | MODE_W | Parallel mode word, zero until valid |
| mode_valid | output | 1 | Mode word complete |
| core_rst | output | 1 | Internal reset to the core, active high |

## Verification
Every edge is counted from the first edge at which power_good is sampled high. mode_clk follows R1 after each edge n. mode_valid and the full word are due right after edge DIV/2 + (MODE_W-1)*DIV, and core_rst falls one edge after that. Reset inputs raise core_rst in the same cycle with no edge, and release it only after the next edge. The bench drives inputs on falling edges and counts edges itself. During every load it compares mode_clk, mode_valid, mode_bits and core_rst against these formulas after each edge. Combinational paths are sampled a short delay after the input change, and registered releases are sampled one falling edge after the rising edge that must cause them.

// File: rtl/boot_pkg.sv
package boot_pkg;

    // Phase of the serial mode loader.
    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_SHIFT = 2'd1,
        LD_DONE  = 2'd2
    } load_phase_e;

    // Reset requests as seen at the block edge.
    typedef struct packed {
        logic cold;
        logic warm;
    } rst_req_t;

    // True on the divider count after which the mode clock rises.
    function automatic logic at_rise_point(input int unsigned cnt,
                                           input int unsigned div);
        return cnt == (div / 2) - 1;
    endfunction

endpackage

// File: rtl/mode_clk_gen.sv
module mode_clk_gen
    import boot_pkg::*;
#(
    parameter int unsigned DIV = 256
) (
    input  logic clk,
    input  logic run,
    output logic mode_clk,
    output logic sample_en
);
    localparam int unsigned CW = $clog2(DIV);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!run) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    // Upper half of the count is the high phase.
    assign mode_clk  = cnt[CW-1];
    assign sample_en = run && at_rise_point(32'(cnt), DIV);

endmodule

// File: rtl/mode_shift.sv
module mode_shift
    import boot_pkg::*;
#(
    parameter int unsigned MODE_W = 256
) (
    input  logic              clk,
    input  logic              run,
    input  logic              sample_en,
    input  logic              din,
    output logic [MODE_W-1:0] bits,
    output logic              valid
);
    localparam int unsigned BW = $clog2(MODE_W);
    localparam logic [BW-1:0] LAST_IDX = BW'(MODE_W - 1);

    load_phase_e       phase;
    logic [BW-1:0]     idx;
    logic [MODE_W-1:0] sreg;

    always_ff @(posedge clk) begin
        if (!run) begin
            phase <= LD_IDLE;
            idx   <= '0;
            sreg  <= '0;
        end else if (phase != LD_DONE && sample_en) begin
            // New bit enters at the top; after MODE_W shifts the first bit is bit 0.
            sreg <= {din, sreg[MODE_W-1:1]};
            if (idx == LAST_IDX) begin
                phase <= LD_DONE;
            end else begin
                phase <= LD_SHIFT;
                idx   <= idx + BW'(1);
            end
        end
    end

    assign valid = (phase == LD_DONE);
    assign bits  = valid ? sreg : '0;

    // R4
    valid_hold_chk: assert property (@(posedge clk) disable iff (!run)
        valid |=> valid);

    // R4
    bits_stable_chk: assert property (@(posedge clk) disable iff (!run)
        valid |=> $stable(bits));

endmodule

// File: rtl/reset_seq.sv
module reset_seq
    import boot_pkg::*;
(
    input  logic     clk,
    input  logic     power_good,
    input  logic     valid,
    input  rst_req_t req,
    output logic     core_rst
);
    logic hold_q;

    always_ff @(posedge clk) begin
        if (!power_good) begin
            hold_q <= 1'b1;
        end else begin
            hold_q <= !valid || req.cold || req.warm;
        end
    end

    // Requests reach the core at once; release waits for a clock edge.
    assign core_rst = hold_q || req.cold || req.warm || !power_good;

    // R6
    always_comb begin
        hold_until_valid_chk: assert (valid || core_rst);
    end

    // R7
    release_chk: assert property (@(posedge clk) disable iff (!power_good)
        $fell(core_rst) |-> (valid && !req.cold && !req.warm));

endmodule

// File: rtl/boot_reset_ctrl.sv
module boot_reset_ctrl
    import boot_pkg::*;
#(
    parameter int unsigned DIV    = 256,
    parameter int unsigned MODE_W = 256
) (
    input  logic              clk,
    input  logic              power_good,
    input  logic              cold_rst_in,
    input  logic              warm_rst_in,
    input  logic              mode_in,
    output logic              mode_clk,
    output logic [MODE_W-1:0] mode_bits,
    output logic              mode_valid,
    output logic              core_rst
);
    localparam int unsigned CW = $clog2(DIV);

    logic     sample_en;
    rst_req_t req;

    assign req.cold = cold_rst_in;
    assign req.warm = warm_rst_in;

    mode_clk_gen #(.DIV(DIV)) u_div (
        .clk       (clk),
        .run       (power_good),
        .mode_clk  (mode_clk),
        .sample_en (sample_en)
    );

    mode_shift #(.MODE_W(MODE_W)) u_shift (
        .clk       (clk),
        .run       (power_good),
        .sample_en (sample_en),
        .din       (mode_in),
        .bits      (mode_bits),
        .valid     (mode_valid)
    );

    reset_seq u_rst (
        .clk        (clk),
        .power_good (power_good),
        .valid      (mode_valid),
        .req        (req),
        .core_rst   (core_rst)
    );

    // Half-period monitor for the mode clock.
    logic          mclk_d;
    logic          mclk_seen;
    logic [CW-1:0] hp_cnt;
    logic          mclk_chg;

    assign mclk_chg = (mode_clk != mclk_d);

    always_ff @(posedge clk) begin
        if (!power_good) begin
            mclk_d    <= 1'b0;
            mclk_seen <= 1'b0;
            hp_cnt    <= '0;
        end else begin
            mclk_d <= mode_clk;
            if (mclk_chg) begin
                mclk_seen <= 1'b1;
                hp_cnt    <= CW'(1);
            end else begin
                hp_cnt <= hp_cnt + CW'(1);
            end
        end
    end

    // R1
    half_period_chk: assert property (@(posedge clk) disable iff (!power_good)
        (mclk_chg && mclk_seen) |-> (hp_cnt == CW'(DIV / 2)));

endmodule

// File: tb/test_boot_reset_ctrl.sv
module test_boot_reset_ctrl;
    localparam int DIV    = 8;
    localparam int W      = 16;
    localparam int LAST_N = DIV / 2 + (W - 1) * DIV;

    logic         clk = 1'b0;
    logic         power_good = 1'b0;
    logic         cold_rst_in = 1'b1;
    logic         warm_rst_in = 1'b1;
    logic         mode_in = 1'b0;
    logic         mode_clk;
    logic [W-1:0] mode_bits;
    logic         mode_valid;
    logic         core_rst;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    boot_reset_ctrl #(.DIV(DIV), .MODE_W(W)) i_boot_reset_ctrl (
        .clk         (clk),
        .power_good  (power_good),
        .cold_rst_in (cold_rst_in),
        .warm_rst_in (warm_rst_in),
        .mode_in     (mode_in),
        .mode_clk    (mode_clk),
        .mode_bits   (mode_bits),
        .mode_valid  (mode_valid),
        .core_rst    (core_rst)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // Full or partial load; edge n counted from the first edge with power_good high.
    task automatic run_load(input logic [W-1:0] pat, input int cycles, input bit hold_rst);
        @(negedge clk);
        warm_rst_in = hold_rst;
        cold_rst_in = 1'b0;
        power_good  = 1'b1;
        mode_in     = pat[0];
        for (int n = 1; n <= cycles; n++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R1 mode_clk", 32'(mode_clk), 32'((n % DIV) >= DIV / 2));
            chk("R3 mode_valid", 32'(mode_valid), 32'(n >= LAST_N));
            chk("R2 mode_bits", 32'(mode_bits), (n >= LAST_N) ? 32'(pat) : 32'd0);
            chk("R7 core_rst", 32'(core_rst), 32'(hold_rst || n <= LAST_N));
            if (n / DIV < W) mode_in = pat[n / DIV];
            else mode_in = ~pat[n % W];   // R4: traffic after loading
        end
    endtask

    task automatic drop_power();
        @(negedge clk);
        power_good = 1'b0;
        #1;
        chk("R8 core_rst on power drop", 32'(core_rst), 32'd1);
        @(posedge clk);
        @(negedge clk);
        chk("R8 mode_valid cleared", 32'(mode_valid), 32'd0);
        chk("R8 mode_bits cleared", 32'(mode_bits), 32'd0);
        chk("R8 mode_clk low", 32'(mode_clk), 32'd0);
        @(negedge clk);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R8 reset mode_clk", 32'(mode_clk), 32'd0);
        chk("R8 reset mode_valid", 32'(mode_valid), 32'd0);
        chk("R3 reset mode_bits", 32'(mode_bits), 32'd0);
        chk("R6 reset core_rst", 32'(core_rst), 32'd1);
        cold_rst_in = 1'b0;
        warm_rst_in = 1'b0;
        #1;
        chk("R6 core_rst with power low", 32'(core_rst), 32'd1);

        run_load(16'hA5C3, LAST_N + 16, 1'b0);

        // Warm reset keeps the word.
        @(negedge clk);
        warm_rst_in = 1'b1;
        #1;
        chk("R6 warm raises core_rst", 32'(core_rst), 32'd1);
        for (int i = 0; i < 3 * DIV; i++) begin
            @(negedge clk);
            mode_in = i[0];
        end
        chk("R5 warm keeps valid", 32'(mode_valid), 32'd1);
        chk("R5 warm keeps bits", 32'(mode_bits), 32'h0000A5C3);
        @(negedge clk);
        warm_rst_in = 1'b0;
        #1;
        chk("R7 held until edge", 32'(core_rst), 32'd1);
        @(posedge clk);
        @(negedge clk);
        chk("R7 warm release", 32'(core_rst), 32'd0);

        // Cold reset asserted between edges.
        @(posedge clk);
        #2;
        cold_rst_in = 1'b1;
        #1;
        chk("R6 async cold", 32'(core_rst), 32'd1);
        repeat (2 * DIV) @(posedge clk);
        @(negedge clk);
        chk("R5 cold keeps bits", 32'(mode_bits), 32'h0000A5C3);
        chk("R5 cold keeps valid", 32'(mode_valid), 32'd1);
        cold_rst_in = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R7 cold release", 32'(core_rst), 32'd0);

        drop_power();

        // Interrupted load must not leak into the next one.
        run_load(16'h0F0F, 60, 1'b0);
        drop_power();
        run_load(16'h8001, LAST_N + 6, 1'b0);
        drop_power();
        run_load(16'hFFFF, LAST_N + 6, 1'b0);
        drop_power();

        // Reset held across the whole load.
        run_load(16'h0000, LAST_N + 6, 1'b1);
        warm_rst_in = 1'b0;
        #1;
        chk("R7 held after hold_rst", 32'(core_rst), 32'd1);
        @(posedge clk);
        @(negedge clk);
        chk("R7 release after load", 32'(core_rst), 32'd0);
        drop_power();

        run_load(16'h6D2B, LAST_N + 10, 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule